// File: doc/BRIEF.md
# Prescaled Reloading Interval Timer

This block produces a periodic interrupt for a processor. A small prescaler divides the processor clock by a programmable amount. Each time the prescaler expires, a 16-bit down-counter takes one step. When a step finds the counter already at zero, the block raises a one-cycle interrupt pulse. On that same step it loads the counter again from a separate period register, so the interrupt repeats without software help.

Software reaches the block through a small synchronous register port. It can read and write the enable bit, the prescale value, the period and the live count. Writing the count directly sets the delay before the first interrupt. Clearing the enable bit freezes the timer where it stands.

Top module: `interval_timer`

## Requirements
- R1: After reset (rst_n low at a clock edge), the enable bit, scale, period, count and prescaler are all zero, and irq is low.
- R2: A write occurs at a clock edge with reg_wr high. reg_addr selects the register: 0 is control (bit 0 = enable, other bits read 0), 1 is scale (bits 7:0, upper bits read 0), 2 is period and 3 is count. reg_rdata returns the addressed register combinationally, and a written value is visible from the next cycle.
- R3: While enabled with scale S, the count changes only when the prescaler expires, once every S+1 cycles. At each expiry a nonzero count decreases by exactly one.
- R4: With scale 0, a running count steps on every clock cycle.
- R5: When the prescaler expires and the count is zero, the count loads the period value instead of decrementing. irq is high for exactly the one cycle that follows that clock edge.
- R6: The prescaler loads the scale value each time it expires. A write to scale does not disturb a countdown already in progress and takes effect at the next expiry.
- R7: While the enable bit is clear, the prescaler and the count hold their values and irq stays low.
- R8: A write to period leaves the current count unchanged; the new period is used at the next reload.
- R9: A write to count takes effect at that edge and has priority over any step or reload in the same cycle.
- R10: With period 0 and a zero count, an interrupt occurs on every prescaler expiry (every cycle when scale is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 scale, 2 period, 3 count) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bound checker tests every cycle the local rules that link one cycle to the next. The count holds between prescaler expiries and drops by one at each expiry with a nonzero count. The prescaler reloads from scale on expiry. A pulse on irq always follows a load of the period. A disabled timer keeps everything frozen. The end-to-end timing comes only from the bench scenarios, which compare against a behavioural model on every clock. These scenarios cover the interrupt spacing over many periods, a scale change in the middle of a countdown, a period change that waits for the next reload, and a count write that collides with an expiry.

// File: rtl/it_pkg.sv
// Shared definitions for the interval timer: register select codes.
package it_pkg;
    localparam int ADDR_W = 2;
    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_SCALE  = 2'd1,
        REG_PERIOD = 2'd2,
        REG_COUNT  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/it_regs.sv
// Holds the software-visible configuration: enable, scale and period.
// Writes to the count register are forwarded as a load strobe to the counter.
// Assumes CNT_W >= SCALE_W and a write bus CNT_W bits wide.
module it_regs
    import it_pkg::*;
#(
    parameter int SCALE_W = 8,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [CNT_W-1:0]   reg_wdata,
    output logic               en,
    output logic [SCALE_W-1:0] scale,
    output logic [CNT_W-1:0]   period,
    output logic               cnt_load
);
    // Decode a write to the live count for the counter.
    assign cnt_load = reg_wr && (reg_addr == REG_COUNT);

    // Configuration register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            scale  <= '0;
            period <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                REG_CTRL:   en     <= reg_wdata[0];
                REG_SCALE:  scale  <= reg_wdata[SCALE_W-1:0];
                REG_PERIOD: period <= reg_wdata;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/it_prescaler.sv
// Cycle prescaler: counts down from the scale value and issues a one-cycle
// tick when it sits at zero while enabled, then reloads from scale.
// Assumes scale may change at any time; the new value is used on the next reload.
module it_prescaler #(
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick,
    output logic [SCALE_W-1:0] pcnt
);
    // Expiry is the zero state while running.
    assign tick = en && (pcnt == '0);

    // Step down, or reload on expiry; hold while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)    pcnt <= '0;
        else if (tick) pcnt <= scale;
        else if (en)   pcnt <= pcnt - 1'b1;
    end
endmodule

// File: rtl/it_counter.sv
// Main down-counter: steps on each prescaler tick, reloads from the period
// when a tick finds it at zero, and raises a registered one-cycle interrupt.
// Assumes a software load has priority over the tick in the same cycle.
module it_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);
    logic at_zero;
    assign at_zero = (cnt == '0);

    // Count value: software load, reload at zero, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (load)    cnt <= load_val;
        else if (tick)    cnt <= at_zero ? period : cnt - 1'b1;
    end

    // Interrupt pulse for the tick that finds the count at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= tick && at_zero;
    end
endmodule

// File: rtl/interval_timer.sv
// Top of the prescaled reloading interval timer. Ties the register block,
// prescaler and counter together and provides the combinational read mux.
// Assumes the data bus is CNT_W bits and CNT_W >= SCALE_W.
module interval_timer
    import it_pkg::*;
#(
    parameter int SCALE_W = 8,
    parameter int CNT_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [it_pkg::ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]         reg_wdata,
    output logic [CNT_W-1:0]         reg_rdata,
    output logic                     irq
);
    localparam int PAD_W = CNT_W - SCALE_W;

    logic               en;
    logic [SCALE_W-1:0] scale;
    logic [CNT_W-1:0]   period;
    logic               cnt_load;
    logic               tick;
    logic [SCALE_W-1:0] pcnt;
    logic [CNT_W-1:0]   cnt;

    it_regs #(.SCALE_W(SCALE_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .en(en), .scale(scale), .period(period),
        .cnt_load(cnt_load)
    );

    it_prescaler #(.SCALE_W(SCALE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .scale(scale),
        .tick(tick), .pcnt(pcnt)
    );

    it_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
        .load_val(reg_wdata), .period(period), .cnt(cnt), .irq(irq)
    );

    // Read mux for the addressed register.
    always_comb begin
        case (reg_addr)
            REG_CTRL:   reg_rdata = {{(CNT_W-1){1'b0}}, en};
            REG_SCALE:  reg_rdata = {{PAD_W{1'b0}}, scale};
            REG_PERIOD: reg_rdata = period;
            default:    reg_rdata = cnt;
        endcase
    end
endmodule

// File: rtl/interval_timer_chk.sv
// Cycle-level protocol checker for interval_timer, attached with bind.
// Assumes rst_n is held low at the first clock edges.
module interval_timer_chk
    import it_pkg::*;
#(
    parameter int SCALE_W = 8,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               en,
    input logic [SCALE_W-1:0] scale,
    input logic [SCALE_W-1:0] pcnt,
    input logic [CNT_W-1:0]   period,
    input logic [CNT_W-1:0]   cnt,
    input logic               irq
);
    logic cnt_wr;
    assign cnt_wr = reg_wr && (reg_addr == REG_COUNT);

    // R3: between expiries and without a count write, the count holds.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(en && pcnt == '0) && !cnt_wr) |-> $stable(cnt));

    // R3: an expiry with a nonzero count steps down by one.
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en && pcnt == '0 && cnt != '0 && !cnt_wr)
            |-> cnt == CNT_W'($past(cnt) - 1'b1));

    // R5: an interrupt pulse always comes with the period just loaded.
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(cnt_wr)) |-> cnt == $past(period));

    // R6: the prescaler restarts from scale after each expiry.
    p_prescale_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en && pcnt == '0) |-> pcnt == $past(scale));

    // R7: disabled timer freezes the prescaler and raises no interrupt.
    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en) |-> ($stable(pcnt) && !irq));
endmodule

bind interval_timer interval_timer_chk #(.SCALE_W(SCALE_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .en(en), .scale(scale), .pcnt(pcnt), .period(period), .cnt(cnt), .irq(irq)
);

// File: tb/interval_timer_test.sv
// Bench for interval_timer: a behavioural model runs beside the design and
// irq plus the addressed read data are compared on every clock.
module interval_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd3;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int vectors = 0;
    int errors = 0;
    int irq_seen = 0;
    string cur_req = "R1";
    bit finished = 0;

    // Model state
    int m_en, m_scale, m_per, m_cnt, m_pc, m_irq;

    interval_timer uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    // Behavioural reference, advanced at every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_scale = 0; m_per = 0; m_cnt = 0; m_pc = 0; m_irq = 0;
        end else begin
            bit t;
            int nxt_pc, nxt_cnt;
            t = (m_en != 0) && (m_pc == 0);
            nxt_pc = m_pc;
            if (t) nxt_pc = m_scale;
            else if (m_en != 0) nxt_pc = m_pc - 1;
            nxt_cnt = m_cnt;
            if (reg_wr && reg_addr == 2'd3) nxt_cnt = reg_wdata;   // R9
            else if (t) nxt_cnt = (m_cnt == 0) ? m_per : m_cnt - 1;
            m_irq = (t && m_cnt == 0) ? 1 : 0;
            m_pc = nxt_pc;
            m_cnt = nxt_cnt;
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: m_en = reg_wdata[0];
                    2'd1: m_scale = reg_wdata[7:0];
                    2'd2: m_per = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic int model_read(input logic [1:0] a);
        case (a)
            2'd0: return m_en;
            2'd1: return m_scale;
            2'd2: return m_per;
            default: return m_cnt;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(cur_req, int'(irq), m_irq, "irq");
            check(cur_req, int'(reg_rdata), model_read(reg_addr), "rdata");
            if (irq) irq_seen++;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_wr = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1: all registers read zero after reset, no interrupt
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            #1;
            check("R1", int'(reg_rdata), 0, "reset read");
            check("R1", int'(irq), 0, "reset irq");
            @(negedge clk); #1;
        end
        // R2: register readback while disabled (also frozen, R7)
        cur_req = "R2";
        wr(2'd1, 16'hFF03);
        wr(2'd2, 16'h1234);
        wr(2'd3, 16'hBEEF);
        for (int a = 0; a < 4; a++) begin
            @(negedge clk); #1 reg_addr = 2'(a);
        end
        #1;
        check("R2", int'(reg_rdata), 16'hBEEF, "count readback");
        // R3: scale 3, count 6, period 0x10
        cur_req = "R3";
        wr(2'd3, 16'd6);
        wr(2'd2, 16'h0010);
        wr(2'd0, 16'd1);
        run(60);
        // R6: scale change mid countdown
        cur_req = "R6";
        wr(2'd1, 16'd1);
        run(30);
        // R4: scale 0 steps every cycle
        cur_req = "R4";
        wr(2'd1, 16'd0);
        wr(2'd3, 16'd2);
        wr(2'd2, 16'd3);
        run(25);
        // R5: irq spacing with period 4 at scale 0
        cur_req = "R5";
        wr(2'd2, 16'd4);
        irq_seen = 0;
        run(50);
        check("R5", (irq_seen >= 8) ? 1 : 0, 1, "irq pulses seen");
        // R8: period change does not touch the count
        cur_req = "R8";
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd7);
        run(60);
        // R9: count writes, repeated to hit expiry cycles
        cur_req = "R9";
        for (int k = 0; k < 4; k++) begin
            wr(2'd3, 16'(16'h20 + k));
            run(k + 1);
        end
        wr(2'd3, 16'd0);
        run(10);
        // R7: disable freezes
        cur_req = "R7";
        wr(2'd0, 16'd0);
        run(20);
        @(negedge clk); #1 reg_addr = 2'd0;
        run(2);
        wr(2'd0, 16'd1);
        run(10);
        // R10: period 0 with zero count
        cur_req = "R10";
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd0);
        wr(2'd3, 16'd0);
        run(12);
        wr(2'd1, 16'd2);
        run(15);
        finish_run();
    end
endmodule